// File: doc/BRIEF.md
# Instruction Fetch and Branch Control Unit

This block is the front end of a five-stage in-order pipeline (fetch, decode, execute, memory access, write back). It owns the program counter and presents a fetch address to a combinational instruction-memory read port. It also carries each fetched word, with its address, through the stage registers, and reports per-stage valid bits and a retirement trace. Unconditional jumps are recognised in decode. Conditional branches take their outcome from an execute-stage condition input, because the execute datapath is outside this block.

A two-bit policy input picks how the slot after a branch is handled. In freeze mode the slot is replaced by a bubble. In delay-slot mode the next instruction in program order always runs. The two static-prediction modes guess taken or not taken and flush the wrong-path work when the guess fails. A NOP is the all-zero word, and the block forms it by clearing a stage valid bit. The reset input is asynchronous and active low, and it is expected to be released in step with the clock.

Top module: `fetch_branch_unit`

## Requirements
- R1: While reset is low, the fetch address is 0, stage valid bits 1 to 4 are clear, and nothing retires. Fetch starts at address 0 once reset is high.
- R2: With no branch in flight, the fetch address rises by one each cycle and retirement reports consecutive addresses on consecutive cycles.
- R3: Freeze mode (policy 0): a jump (opcode 4'hF in bits 15:12, absolute target in bits 11:0) in decode squashes the word fetched in that cycle, so the next retirement after the jump is its target, two cycles later.
- R4: Delay-slot mode (policy 1): the word at branch address + 1 always retires, for jumps and for conditional branches whether taken or not. A taken branch then retires its target two cycles after the slot.
- R5: Taken-prediction mode (policy 2): the fetch after any jump or conditional branch (opcode 4'hE, target in bits 11:0) uses the branch target, so a correct guess retires the target on the next cycle.
- R6: Not-taken-prediction mode (policy 3): fetch stays sequential past branches. A jump redirects from decode with one squashed slot, and a not-taken branch costs no cycle.
- R7: A conditional branch whose condition input in execute disagrees with its guess flushes the decode and execute slots (except in delay-slot mode) and restarts fetch at the correct address, so the next retirement comes three cycles after the branch.
- R8: In freeze mode a conditional branch in decode holds the fetch address and inserts a bubble. A taken branch retires its target three cycles after itself, and a not-taken one retires its successor two cycles after itself.
- R9: A redirect from a branch in execute takes priority over a jump in decode at the same cycle, so that jump never retires and its target is never fetched.
- R10: A high stall input holds the fetch address and every stage register, and it suppresses retirement. After release, retirement continues with no address lost or repeated.
- R11: The condition input has no effect while no conditional branch is in execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Hold all state for this cycle |
| mode_i | input | 2 | Branch-slot policy: 0 freeze, 1 delay slot, 2 predict taken, 3 predict not taken |
| ex_taken_i | input | 1 | Condition result for the conditional branch in execute |
| imem_addr_o | output | 16 | Fetch address |
| imem_rdata_i | input | 16 | Instruction word at the fetch address, same cycle |
| dec_valid_o | output | 1 | Decode slot holds a live instruction |
| dec_pc_o | output | 16 | Address of the decode-stage instruction |
| dec_instr_o | output | 16 | Decode-stage instruction word |
| stage_valid_o | output | STAGES (5) | Bit 0 is fetch slot kept, bits 1 to 4 are decode through write-back valid |
| squash_o | output | 2 | Bit 0 is fetch slot killed this cycle, bit 1 is decode slot killed |
| retire_valid_o | output | 1 | An instruction retires this cycle |
| retire_pc_o | output | 16 | Address of the retiring instruction |
| retire_instr_o | output | 16 | Word of the retiring instruction |

## Verification
The hardest case to reach is an execute-stage misprediction in the same cycle as a jump in decode that lies on the wrong path. The two redirects compete, and only the priority decides the fetch address. The stimulus puts a conditional branch directly before a jump, in not-taken mode with the condition forced true, so the jump sits in decode exactly when the branch resolves. Every mode and condition pair is run on small programs, and the retirement trace is compared both in address order and in cycle spacing, which exposes a bubble that is missing or extra.

// File: rtl/fbu_pkg.sv
`timescale 1ns/1ps
package fbu_pkg;
  localparam int WORD_W     = 16;
  localparam int OPC_W      = 4;
  localparam int TGT_W      = 12;
  localparam int NUM_STAGES = 5;

  localparam logic [OPC_W-1:0] OPC_JUMP   = 4'hF;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 4'hE;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    MODE_FREEZE    = 2'd0,
    MODE_DELAY     = 2'd1,
    MODE_TAKEN     = 2'd2,
    MODE_NOT_TAKEN = 2'd3
  } bmode_e;

  typedef struct packed {
    logic  valid;
    logic  pred_tk;
    word_t pc;
    word_t instr;
  } slot_t;

  function automatic logic is_jump(word_t w);
    return w[WORD_W-1 -: OPC_W] == OPC_JUMP;
  endfunction

  function automatic logic is_branch(word_t w);
    return w[WORD_W-1 -: OPC_W] == OPC_BRANCH;
  endfunction

  function automatic word_t target_of(word_t w);
    return {{(WORD_W-TGT_W){1'b0}}, w[TGT_W-1:0]};
  endfunction
endpackage

// File: rtl/fbu_pc_gen.sv
`timescale 1ns/1ps
module fbu_pc_gen
  import fbu_pkg::*;
#(
  parameter word_t RESET_PC = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  stall_i,
  input  logic  redirect_i,
  input  word_t redirect_pc_i,
  input  logic  hold_i,
  input  logic  predict_i,
  input  word_t predict_pc_i,
  output word_t pc_o
);
  word_t pc_q;
  word_t pc_d;
  logic  pc_en;

  // priority: resolved redirect, then freeze hold, then prediction, then +1
  always_comb begin
    pc_d = pc_q + word_t'(1);
    if (redirect_i)     pc_d = redirect_pc_i;
    else if (hold_i)    pc_d = pc_q;
    else if (predict_i) pc_d = predict_pc_i;
  end

  assign pc_en = ~stall_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= RESET_PC;
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  p_pc_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> $stable(pc_q));

  p_pc_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && !redirect_i && !hold_i && !predict_i) |=> (pc_q == $past(pc_q) + word_t'(1)));

  p_pc_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && redirect_i) |=> (pc_q == $past(redirect_pc_i)));
endmodule

// File: rtl/fbu_hazard_ctl.sv
`timescale 1ns/1ps
module fbu_hazard_ctl
  import fbu_pkg::*;
(
  input  bmode_e mode_i,
  input  word_t  fetch_instr_i,
  input  slot_t  id_i,
  input  slot_t  ex_i,
  input  logic   ex_taken_i,
  output logic   predict_o,
  output word_t  predict_pc_o,
  output logic   redirect_o,
  output word_t  redirect_pc_o,
  output logic   hold_o,
  output logic   kill_ifid_o,
  output logic   kill_idex_o,
  output logic   ex_mispredict_o
);
  logic  delay_mode;
  logic  ex_is_br;
  logic  id_jump;
  logic  id_br_wait;
  word_t ex_fix_pc;

  always_comb begin
    delay_mode      = (mode_i == MODE_DELAY);
    ex_is_br        = ex_i.valid && is_branch(ex_i.instr);
    ex_mispredict_o = ex_is_br && (ex_taken_i != ex_i.pred_tk);
    ex_fix_pc       = ex_taken_i ? target_of(ex_i.instr) : ex_i.pc + word_t'(1);

    // a jump already steered at fetch carries pred_tk and needs no redirect
    id_jump    = id_i.valid && is_jump(id_i.instr) && !id_i.pred_tk;
    id_br_wait = id_i.valid && is_branch(id_i.instr) && (mode_i == MODE_FREEZE);

    predict_o    = (mode_i == MODE_TAKEN) &&
                   (is_jump(fetch_instr_i) || is_branch(fetch_instr_i));
    predict_pc_o = target_of(fetch_instr_i);

    // the older instruction in execute wins over decode
    redirect_o    = ex_mispredict_o || id_jump;
    redirect_pc_o = ex_mispredict_o ? ex_fix_pc : target_of(id_i.instr);
    hold_o        = id_br_wait;

    kill_ifid_o = ex_mispredict_o || (id_jump && !delay_mode) || id_br_wait;
    kill_idex_o = ex_mispredict_o && !delay_mode;
  end
endmodule

// File: rtl/fbu_pipe_regs.sv
`timescale 1ns/1ps
module fbu_pipe_regs
  import fbu_pkg::*;
#(
  parameter int STAGES = NUM_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_i,
  input  slot_t             fetch_i,
  input  logic              kill_ifid_i,
  input  logic              kill_idex_i,
  output slot_t             id_o,
  output slot_t             ex_o,
  output slot_t             wb_o,
  output logic [STAGES-1:1] valid_o
);
  localparam int LAST = STAGES - 1;

  slot_t pipe_q [1:LAST];
  slot_t pipe_d [1:LAST];
  logic  adv_en;

  assign adv_en = ~stall_i;

  always_comb begin
    pipe_d[1]       = fetch_i;
    pipe_d[1].valid = fetch_i.valid & ~kill_ifid_i;
    pipe_d[2]       = pipe_q[1];
    pipe_d[2].valid = pipe_q[1].valid & ~kill_idex_i;
    for (int k = 3; k <= LAST; k++) pipe_d[k] = pipe_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 1; k <= LAST; k++) pipe_q[k] <= '0;
    end else if (adv_en) begin
      for (int k = 1; k <= LAST; k++) pipe_q[k] <= pipe_d[k];
    end
  end

  for (genvar g = 1; g <= LAST; g++) begin : g_valid
    assign valid_o[g] = pipe_q[g].valid;
  end

  assign id_o = pipe_q[1];
  assign ex_o = pipe_q[2];
  assign wb_o = pipe_q[LAST];

  p_kill_ifid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && kill_ifid_i) |=> !pipe_q[1].valid);

  p_kill_idex_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && kill_idex_i) |=> !pipe_q[2].valid);

  p_stage_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> ($stable(valid_o) && $stable(pipe_q[LAST].pc)));
endmodule

// File: rtl/fetch_branch_unit.sv
`timescale 1ns/1ps
module fetch_branch_unit
  import fbu_pkg::*;
#(
  parameter word_t RESET_PC = '0,
  parameter int    STAGES   = NUM_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_i,
  input  logic [1:0]        mode_i,
  input  logic              ex_taken_i,
  output logic [WORD_W-1:0] imem_addr_o,
  input  logic [WORD_W-1:0] imem_rdata_i,
  output logic              dec_valid_o,
  output logic [WORD_W-1:0] dec_pc_o,
  output logic [WORD_W-1:0] dec_instr_o,
  output logic [STAGES-1:0] stage_valid_o,
  output logic [1:0]        squash_o,
  output logic              retire_valid_o,
  output logic [WORD_W-1:0] retire_pc_o,
  output logic [WORD_W-1:0] retire_instr_o
);
  bmode_e mode;
  word_t  pc;
  slot_t  fetch_slot, id_slot, ex_slot, wb_slot;
  logic   predict, redirect, hold, kill_ifid, kill_idex, ex_mis;
  word_t  predict_pc, redirect_pc;
  logic [STAGES-1:1] vld;

  assign mode = bmode_e'(mode_i);

  fbu_pc_gen #(.RESET_PC(RESET_PC)) i_pc_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .stall_i      (stall_i),
    .redirect_i   (redirect),
    .redirect_pc_i(redirect_pc),
    .hold_i       (hold),
    .predict_i    (predict),
    .predict_pc_i (predict_pc),
    .pc_o         (pc)
  );

  always_comb begin
    fetch_slot.valid   = 1'b1;
    fetch_slot.pred_tk = predict;
    fetch_slot.pc      = pc;
    fetch_slot.instr   = imem_rdata_i;
  end

  fbu_hazard_ctl i_hazard (
    .mode_i         (mode),
    .fetch_instr_i  (imem_rdata_i),
    .id_i           (id_slot),
    .ex_i           (ex_slot),
    .ex_taken_i     (ex_taken_i),
    .predict_o      (predict),
    .predict_pc_o   (predict_pc),
    .redirect_o     (redirect),
    .redirect_pc_o  (redirect_pc),
    .hold_o         (hold),
    .kill_ifid_o    (kill_ifid),
    .kill_idex_o    (kill_idex),
    .ex_mispredict_o(ex_mis)
  );

  fbu_pipe_regs #(.STAGES(STAGES)) i_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall_i    (stall_i),
    .fetch_i    (fetch_slot),
    .kill_ifid_i(kill_ifid),
    .kill_idex_i(kill_idex),
    .id_o       (id_slot),
    .ex_o       (ex_slot),
    .wb_o       (wb_slot),
    .valid_o    (vld)
  );

  assign imem_addr_o           = pc;
  assign dec_valid_o           = id_slot.valid;
  assign dec_pc_o              = id_slot.pc;
  assign dec_instr_o           = id_slot.instr;
  assign stage_valid_o[0]      = ~kill_ifid;
  assign stage_valid_o[STAGES-1:1] = vld;
  assign squash_o              = {kill_idex, kill_ifid};
  assign retire_valid_o        = wb_slot.valid & ~stall_i;
  assign retire_pc_o           = wb_slot.pc;
  assign retire_instr_o        = wb_slot.instr;

  p_freeze_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FREEZE && id_slot.valid && is_jump(id_slot.instr) && !ex_mis && !stall_i)
    |=> (!id_slot.valid && imem_addr_o == $past(target_of(id_slot.instr))));

  p_delay_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_DELAY && id_slot.valid &&
     (is_jump(id_slot.instr) || is_branch(id_slot.instr)) && !ex_mis && !stall_i)
    |=> (id_slot.valid && id_slot.pc == $past(id_slot.pc) + word_t'(1)));

  p_taken_guess_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TAKEN && (is_jump(imem_rdata_i) || is_branch(imem_rdata_i)) &&
     !redirect && !stall_i)
    |=> (imem_addr_o == $past(target_of(imem_rdata_i))));

  p_ex_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_mis && !stall_i && mode != MODE_DELAY) |=> (!id_slot.valid && !ex_slot.valid));

  p_ex_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_mis && !stall_i)
    |=> (imem_addr_o == $past(ex_taken_i ? target_of(ex_slot.instr)
                                         : ex_slot.pc + word_t'(1))));
endmodule

// File: tb/test_fetch_branch_unit.sv
`timescale 1ns/1ps
module test_fetch_branch_unit;
  import fbu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n, stall, ex_tk;
  logic [1:0]  mode;
  logic [15:0] imem_addr, imem_rdata, dec_pc, dec_instr, ret_pc, ret_instr;
  logic        dec_valid, ret_valid;
  logic [4:0]  stage_valid;
  logic [1:0]  squash;

  always #5 clk = ~clk;

  logic [15:0] mem [0:63];
  assign imem_rdata = mem[imem_addr[5:0]];

  fetch_branch_unit i_fetch_branch_unit (
    .clk(clk), .rst_n(rst_n), .stall_i(stall), .mode_i(mode), .ex_taken_i(ex_tk),
    .imem_addr_o(imem_addr), .imem_rdata_i(imem_rdata),
    .dec_valid_o(dec_valid), .dec_pc_o(dec_pc), .dec_instr_o(dec_instr),
    .stage_valid_o(stage_valid), .squash_o(squash),
    .retire_valid_o(ret_valid), .retire_pc_o(ret_pc), .retire_instr_o(ret_instr)
  );

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int log_n = 0;
  logic [15:0] log_pc [0:31];
  int          log_cyc [0:31];
  logic [15:0] exp_pc [0:15];
  int          exp_gap [0:15];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && ret_valid && log_n < 32) begin
      log_pc[log_n]  = ret_pc;
      log_cyc[log_n] = cyc;
      log_n++;
    end
  end

  always @(posedge clk) begin
    if (cyc == 50000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic load_plain();
    for (int i = 0; i < 64; i++) mem[i] = 16'h1000 | 16'(i);
  endtask

  task automatic set_exp(input int idx, input int pc, input int gap);
    exp_pc[idx]  = 16'(pc);
    exp_gap[idx] = gap;
  endtask

  task automatic start(input logic [1:0] m, input logic tk);
    @(posedge clk); #2;
    rst_n = 1'b0; stall = 1'b0; mode = m; ex_tk = tk;
    repeat (2) @(posedge clk);
    #2;
    log_n = 0;
    rst_n = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // gap 0 means spacing is not checked at that index
  task automatic expect_log(input string req, input int n);
    chk(req, "retire count ok", int'(log_n >= n), 1);
    for (int i = 0; i < n; i++) begin
      chk(req, $sformatf("retire pc #%0d", i), log_pc[i], exp_pc[i]);
      if (i > 0 && exp_gap[i] != 0)
        chk(req, $sformatf("retire gap #%0d", i), log_cyc[i] - log_cyc[i-1], exp_gap[i]);
    end
  endtask

  // R1: reset state and first fetch
  task automatic t_reset();
    load_plain();
    @(posedge clk); #2;
    rst_n = 1'b0; stall = 1'b0; mode = 2'd0; ex_tk = 1'b0;
    @(negedge clk);
    chk("R1", "stage valid 4:1", stage_valid[4:1], 0);
    chk("R1", "fetch addr", imem_addr, 0);
    chk("R1", "retire valid", ret_valid, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "first fetch addr", imem_addr, 0);
    @(negedge clk);
    chk("R1", "second fetch addr", imem_addr, 1);
  endtask

  // R2: straight-line code
  task automatic t_seq();
    load_plain();
    start(2'd0, 1'b0);
    run(14);
    for (int i = 0; i < 8; i++) set_exp(i, i, 1);
    expect_log("R2", 8);
  endtask

  // jump at 2 to 0x20; R3 freeze, R4 delay, R5 taken, R6/R11 not taken
  task automatic t_jump(input logic [1:0] m, input logic tk, input string req);
    load_plain();
    mem[2] = 16'hF020;
    start(m, tk);
    run(16);
    set_exp(0, 0, 1); set_exp(1, 1, 1); set_exp(2, 2, 1);
    case (m)
      2'd0:    begin set_exp(3, 16'h20, 2); set_exp(4, 16'h21, 1); end
      2'd1:    begin set_exp(3, 3, 1);      set_exp(4, 16'h20, 1); end
      2'd2:    begin set_exp(3, 16'h20, 1); set_exp(4, 16'h21, 1); end
      default: begin set_exp(3, 16'h20, 2); set_exp(4, 16'h21, 1); end
    endcase
    expect_log(req, 5);
  endtask

  // conditional branch at 1 to 0x20; R4, R5, R6, R7, R8
  task automatic t_branch(input logic [1:0] m, input logic tk, input string req);
    load_plain();
    mem[1] = 16'hE020;
    start(m, tk);
    run(16);
    set_exp(0, 0, 1); set_exp(1, 1, 1);
    case ({m, tk})
      3'b000: begin set_exp(2, 2, 2); set_exp(3, 3, 1); end               // R8 not taken
      3'b001: begin set_exp(2, 16'h20, 3); set_exp(3, 16'h21, 1); end     // R8 taken
      3'b010: begin set_exp(2, 2, 1); set_exp(3, 3, 1); end               // R4 not taken
      3'b011: begin set_exp(2, 2, 1); set_exp(3, 16'h20, 2); end          // R4 taken
      3'b100: begin set_exp(2, 2, 3); set_exp(3, 3, 1); end               // R7 wrong guess
      3'b101: begin set_exp(2, 16'h20, 1); set_exp(3, 16'h21, 1); end     // R5 right guess
      3'b110: begin set_exp(2, 2, 1); set_exp(3, 3, 1); end               // R6 right guess
      default: begin set_exp(2, 16'h20, 3); set_exp(3, 16'h21, 1); end    // R7 wrong guess
    endcase
    expect_log(req, 4);
  endtask

  // R9: jump at 2 sits in decode while the branch at 1 mispredicts
  task automatic t_priority();
    load_plain();
    mem[1] = 16'hE020;
    mem[2] = 16'hF030;
    start(2'd3, 1'b1);
    run(16);
    set_exp(0, 0, 1); set_exp(1, 1, 1); set_exp(2, 16'h20, 3); set_exp(3, 16'h21, 1);
    expect_log("R9", 4);
  endtask

  // R10: stall holds everything, nothing lost afterwards
  task automatic t_stall();
    logic [15:0] addr0;
    logic [4:0]  sv0;
    load_plain();
    start(2'd0, 1'b0);
    run(6);
    stall = 1'b1;
    @(negedge clk);
    addr0 = imem_addr;
    sv0   = stage_valid;
    chk("R10", "no retire in stall", ret_valid, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10", "fetch addr held", imem_addr, addr0);
      chk("R10", "stage valid held", stage_valid, sv0);
      chk("R10", "no retire in stall", ret_valid, 0);
    end
    @(posedge clk); #2;
    stall = 1'b0;
    run(10);
    for (int i = 0; i < 10; i++) set_exp(i, i, 0);
    expect_log("R10", 10);
  endtask

  initial begin
    rst_n = 1'b0; stall = 1'b0; mode = 2'd0; ex_tk = 1'b0;
    load_plain();
    t_reset();
    t_seq();
    t_jump(2'd0, 1'b0, "R3");
    t_jump(2'd1, 1'b0, "R4");
    t_jump(2'd2, 1'b0, "R5");
    t_jump(2'd3, 1'b0, "R6");
    t_jump(2'd3, 1'b1, "R11");
    t_jump(2'd0, 1'b1, "R11");
    t_branch(2'd0, 1'b0, "R8");
    t_branch(2'd0, 1'b1, "R8");
    t_branch(2'd1, 1'b0, "R4");
    t_branch(2'd1, 1'b1, "R4");
    t_branch(2'd2, 1'b1, "R5");
    t_branch(2'd2, 1'b0, "R7");
    t_branch(2'd3, 1'b0, "R6");
    t_branch(2'd3, 1'b1, "R7");
    t_priority();
    t_stall();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule